// File: doc/BRIEF.md
# Ring Channel Packet Injector

This block sits between a processing node's electrical port and a unidirectional ring. It accepts one 64-bit word with a 3-bit destination code. It sends the word onto exactly one of eight logical ring channels as a three-beat burst. The first beat carries the destination code, zero-extended to 32 bits. The second beat carries bits 63:32 of the word and the third carries bits 31:0. Every beat is split into a high 16-bit half and a low 16-bit half. Each half drives a bank of per-channel lanes, and only the lane pair of the enabled channel is non-zero.

The word is accepted with a valid/ready handshake. Control is a four-state machine. `ST_IDLE` waits for a word and moves to `ST_ADDR` on acceptance. `ST_ADDR` always moves to `ST_UPPER`, and `ST_UPPER` always moves to `ST_LOWER`. `ST_LOWER` moves to `ST_ADDR` if another word is accepted in that cycle, and to `ST_IDLE` otherwise. The handshake is open in `ST_IDLE` and `ST_LOWER`, so back-to-back words stream at one beat per cycle.

Top module: `ring_injector`

## Requirements
- R1: While reset is asserted and just after it, `ch_en_o` and all lanes are zero and `in_ready_o` is 1.
- R2: A word and its destination are taken only on a cycle with `in_valid_i` and `in_ready_o` both high. `in_ready_o` is low during the address beat and the upper beat.
- R3: During each of the three beats, `ch_en_o` is one-hot and its set bit index equals the destination code (bit i for code i).
- R4: When no burst is in flight, `ch_en_o` is all zero.
- R5: The first beat after acceptance is the address beat. `addr_beat_o` is 1, and the beat value is the destination code in bits 2:0 with zeros above.
- R6: The second beat carries word bits 63:32 and the third carries word bits 31:0, with `addr_beat_o` low for both.
- R7: Channel c uses the slice [16c+15:16c] of `ring_hi_o` and of `ring_lo_o`. Beat bits 31:16 appear on the enabled channel's `ring_hi_o` slice and bits 15:0 on its `ring_lo_o` slice. The slices of every other channel are zero.
- R8: Changes to `in_data_i`, `in_dest_i` or `in_valid_i` while the handshake is closed have no effect on the burst in flight.
- R9: A word accepted during the lower beat begins its address beat in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Node offers a word |
| in_ready_o | output | 1 | Block can take a word this cycle |
| in_data_i | input | 64 | Word from the node |
| in_dest_i | input | 3 | Destination / channel code |
| ch_en_o | output | 8 | One-hot logical channel enable |
| addr_beat_o | output | 1 | Current beat is the address beat |
| ring_hi_o | output | 128 | High 16-bit half for each of 8 channels |
| ring_lo_o | output | 128 | Low 16-bit half for each of 8 channels |

## Verification
A wrong state shows at the ports in the same cycle. Each state fixes the enable pattern, the `addr_beat_o` flag and which word slice reaches the lanes. A skipped or repeated state therefore shows as a misplaced or duplicated slice on the very next beat. A capture register that is overwritten mid-burst shows as foreign data on the upper or lower beat, before the burst ends. A wrong decode shows at once as data on a channel other than the requested one.

// File: rtl/ring_inj_pkg.sv
package ring_inj_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_UPPER = 2'd2,
        ST_LOWER = 2'd3
    } inj_state_t;
endpackage

// File: rtl/dest_onehot.sv
module dest_onehot #(
    parameter int DEST_W = 3,
    localparam int NCH = 1 << DEST_W
) (
    input  logic [DEST_W-1:0] dest_i,
    input  logic              active_i,
    output logic [NCH-1:0]    en_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_en
        assign en_o[c] = active_i && (dest_i == DEST_W'(c));
    end
endmodule

// File: rtl/beat_select.sv
module beat_select
    import ring_inj_pkg::*;
#(
    parameter int PKT_W  = 32,
    parameter int DEST_W = 3,
    localparam int WORD_W = 2 * PKT_W
) (
    input  inj_state_t        state_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DEST_W-1:0] dest_i,
    output logic [PKT_W-1:0]  beat_o,
    output logic              is_addr_o
);
    always_comb begin
        beat_o    = '0;
        is_addr_o = 1'b0;
        unique case (state_i)
            ST_IDLE:  beat_o = '0;
            ST_ADDR: begin
                beat_o    = {{(PKT_W-DEST_W){1'b0}}, dest_i};
                is_addr_o = 1'b1;
            end
            ST_UPPER: beat_o = word_i[WORD_W-1:PKT_W];
            ST_LOWER: beat_o = word_i[PKT_W-1:0];
        endcase
    end
endmodule

// File: rtl/lane_fanout.sv
module lane_fanout #(
    parameter int HALF_W = 16,
    parameter int NCH    = 8
) (
    input  logic [HALF_W-1:0]     half_i,
    input  logic [NCH-1:0]        en_i,
    output logic [NCH*HALF_W-1:0] lanes_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign lanes_o[c*HALF_W +: HALF_W] = en_i[c] ? half_i : '0;
    end
endmodule

// File: rtl/ring_injector.sv
module ring_injector
    import ring_inj_pkg::*;
#(
    parameter int PKT_W  = 32,
    parameter int DEST_W = 3,
    localparam int WORD_W = 2 * PKT_W,
    localparam int HALF_W = PKT_W / 2,
    localparam int NCH    = 1 << DEST_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid_i,
    output logic                  in_ready_o,
    input  logic [WORD_W-1:0]     in_data_i,
    input  logic [DEST_W-1:0]     in_dest_i,
    output logic [NCH-1:0]        ch_en_o,
    output logic                  addr_beat_o,
    output logic [NCH*HALF_W-1:0] ring_hi_o,
    output logic [NCH*HALF_W-1:0] ring_lo_o
);
    inj_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [DEST_W-1:0] dest_q;
    logic [PKT_W-1:0]  beat;
    logic              accept;
    logic              busy;

    // state register and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                word_q <= in_data_i;
                dest_q <= in_dest_i;
            end
        end
    end

    // next state and handshake outputs
    always_comb begin
        in_ready_o = (state_q == ST_IDLE) || (state_q == ST_LOWER);
        accept     = in_valid_i && in_ready_o;
        busy       = (state_q != ST_IDLE);
        state_d    = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_ADDR : ST_IDLE;
            ST_ADDR:  state_d = ST_UPPER;
            ST_UPPER: state_d = ST_LOWER;
            ST_LOWER: state_d = accept ? ST_ADDR : ST_IDLE;
        endcase
    end

    dest_onehot #(.DEST_W(DEST_W)) u_dec (
        .dest_i   (dest_q),
        .active_i (busy),
        .en_o     (ch_en_o)
    );

    beat_select #(.PKT_W(PKT_W), .DEST_W(DEST_W)) u_beat (
        .state_i   (state_q),
        .word_i    (word_q),
        .dest_i    (dest_q),
        .beat_o    (beat),
        .is_addr_o (addr_beat_o)
    );

    lane_fanout #(.HALF_W(HALF_W), .NCH(NCH)) u_hi (
        .half_i  (beat[PKT_W-1:HALF_W]),
        .en_i    (ch_en_o),
        .lanes_o (ring_hi_o)
    );

    lane_fanout #(.HALF_W(HALF_W), .NCH(NCH)) u_lo (
        .half_i  (beat[HALF_W-1:0]),
        .en_i    (ch_en_o),
        .lanes_o (ring_lo_o)
    );

    // assertions
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (word_q == $past(in_data_i)) && (dest_q == $past(in_dest_i)));
    p_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR || state_q == ST_UPPER) |-> !in_ready_o);
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($onehot(ch_en_o) && ch_en_o[dest_q]));
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (ch_en_o == '0));
    p_addr_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> addr_beat_o);
    p_seq_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |=> (state_q == ST_UPPER));
    p_seq_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPPER) |=> (state_q == ST_LOWER));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR || state_q == ST_UPPER) |=> ($stable(word_q) && $stable(dest_q)));
    p_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOWER && in_valid_i) |=> (state_q == ST_ADDR));
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_lane_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en_o[c] |-> (ring_hi_o[c*HALF_W +: HALF_W] == '0 &&
                             ring_lo_o[c*HALF_W +: HALF_W] == '0));
    end
endmodule

// File: tb/ring_injector_bench.sv
module ring_injector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic         in_ready_o;
    logic [63:0]  in_data_i = '0;
    logic [2:0]   in_dest_i = '0;
    logic [7:0]   ch_en_o;
    logic         addr_beat_o;
    logic [127:0] ring_hi_o;
    logic [127:0] ring_lo_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {dest, word}
    localparam logic [66:0] VEC [NV] = '{
        {3'd0, 64'h0123_4567_89AB_CDEF},
        {3'd1, 64'hFFFF_FFFF_FFFF_FFFF},
        {3'd2, 64'h0000_0000_0000_0001},
        {3'd3, 64'h8000_0000_0000_0000},
        {3'd4, 64'hDEAD_BEEF_CAFE_F00D},
        {3'd5, 64'h0000_FFFF_FFFF_0000},
        {3'd6, 64'h5A5A_A5A5_3C3C_C3C3},
        {3'd7, 64'hFFFF_0000_0000_FFFF}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_injector u_ring_injector (
        .clk, .rst_n, .in_valid_i, .in_ready_o, .in_data_i, .in_dest_i,
        .ch_en_o, .addr_beat_o, .ring_hi_o, .ring_lo_o
    );

    function automatic logic [127:0] place(input logic [15:0] v, input int d);
        return 128'(v) << (d * 16);
    endfunction

    task automatic check(input string tag, input logic [7:0] en, input logic ab,
                         input logic [127:0] hi, input logic [127:0] lo, input logic rdy);
        checks++;
        if (ch_en_o !== en || addr_beat_o !== ab || ring_hi_o !== hi ||
            ring_lo_o !== lo || in_ready_o !== rdy) begin
            errors++;
            $display("FAIL %s: en=%h ab=%b hi=%h lo=%h rdy=%b expected en=%h ab=%b hi=%h lo=%h rdy=%b",
                     tag, ch_en_o, addr_beat_o, ring_hi_o, ring_lo_o, in_ready_o,
                     en, ab, hi, lo, rdy);
        end
    endtask

    task automatic check_beat(input string tag, input logic [2:0] d, input logic [31:0] b,
                              input logic ab, input logic rdy);
        check(tag, 8'(1) << d, ab, place(b[31:16], int'(d)), place(b[15:0], int'(d)), rdy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", 8'h00, 1'b0, '0, '0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 8'h00, 1'b0, '0, '0, 1'b1);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  d;
            logic [63:0] w;
            d = VEC[i][66:64];
            w = VEC[i][63:0];
            check("R4 idle before word", 8'h00, 1'b0, '0, '0, 1'b1);
            in_valid_i = 1'b1; in_data_i = w; in_dest_i = d;
            @(negedge clk);
            in_valid_i = 1'b0; in_data_i = ~w; in_dest_i = ~d;
            check_beat("R5 R3 R7 address beat", d, {29'd0, d}, 1'b1, 1'b0);
            @(negedge clk);
            check_beat("R6 R2 upper beat", d, w[63:32], 1'b0, 1'b0);
            @(negedge clk);
            check_beat("R6 lower beat", d, w[31:0], 1'b0, 1'b1);
            @(negedge clk);
        end
        check("R4 idle after table", 8'h00, 1'b0, '0, '0, 1'b1);

        // R2: valid low leaves block idle
        in_data_i = 64'h1111_2222_3333_4444; in_dest_i = 3'd3;
        @(negedge clk);
        check("R2 no accept without valid", 8'h00, 1'b0, '0, '0, 1'b1);

        // R8 and R9: input churn mid-burst, then streaming accept in lower beat
        in_valid_i = 1'b1; in_data_i = 64'hAAAA_BBBB_CCCC_DDDD; in_dest_i = 3'd5;
        @(negedge clk);
        in_data_i = 64'h1357_9BDF_2468_ACE0; in_dest_i = 3'd2;
        check_beat("R8 address beat of first", 3'd5, 32'd5, 1'b1, 1'b0);
        @(negedge clk);
        check_beat("R8 upper unaffected", 3'd5, 32'hAAAA_BBBB, 1'b0, 1'b0);
        @(negedge clk);
        check_beat("R8 lower unaffected", 3'd5, 32'hCCCC_DDDD, 1'b0, 1'b1);
        @(negedge clk);
        in_valid_i = 1'b0;
        check_beat("R9 back-to-back address", 3'd2, 32'd2, 1'b1, 1'b0);
        @(negedge clk);
        check_beat("R9 second upper", 3'd2, 32'h1357_9BDF, 1'b0, 1'b0);
        @(negedge clk);
        check_beat("R9 second lower", 3'd2, 32'h2468_ACE0, 1'b0, 1'b1);
        @(negedge clk);
        check("R4 idle after stream", 8'h00, 1'b0, '0, '0, 1'b1);

        // R1: reset mid-burst
        in_valid_i = 1'b1; in_data_i = 64'hFEED_FACE_0BAD_F00D; in_dest_i = 3'd6;
        @(negedge clk);
        in_valid_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-burst", 8'h00, 1'b0, '0, '0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle after reset", 8'h00, 1'b0, '0, '0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule